// File: doc/BRIEF.md
# Shared Interrupt Distributor

This block takes a handful of common interrupt request lines and hands them to up to four cores. Each common line has three settings: a destination set of cores, a mode word, and a block bit. All of them are written through a single command port that carries an opcode, a line index and a data word. A global switch, also set by command, gates all delivery. Each core receives one output wire per common line. The output vector is flattened so that core `c`, line `i` sits at bit `c*N_IRQ + i`.

A line is delivered in one of two ways. In fixed-destination mode it goes to the cores in its set. In round-robin mode it goes to one core of the set at a time, and a per-line pointer rotates through the set. A trigger flag selects how the input is read. In level mode the output follows the input. In edge mode a 0-to-1 transition of the input produces a single-cycle pulse.

The command port is a valid/ready stream. `cmd_ready` is held high, so the port never applies back-pressure. Every cycle with `cmd_valid` high is one accepted command. Interrupt inputs are taken as already synchronous to `clk`.

Top module: `irq_spread_unit`

## Requirements
- R1: After reset all outputs are low, `cmd_ready` is high, routing is switched off, every line is blocked, every destination set is empty, every pointer is at core 0, and every mode is edge-triggered fixed-destination.
- R2: Opcode 0 sets the global switch to `cmd_data[0]`. While the switch is off, every output stays low whatever the inputs do.
- R3: Opcode 3 sets the block bit of line `cmd_idx` to `cmd_data[0]`. A blocked line (bit = 1) drives no core; writing 0 unblocks it.
- R4: Opcode 1 loads `cmd_data[N_CORES-1:0]` as the destination set of line `cmd_idx`, with bit `c` standing for core `c`. A line with an empty set drives no core.
- R5: In level fixed-destination mode, a routed line drives only the lowest-numbered core of its set, and that output equals the input in the same cycle.
- R6: In edge fixed-destination mode, a 0-to-1 input transition on a routed line gives a one-cycle pulse on every core of its set. A held-high input gives no further pulse.
- R7: In level round-robin mode, a routed line drives exactly one core while its input is high. That core is the first set member found scanning upward, cyclically, from the pointer. When the input falls, the pointer moves to the core after the one served.
- R8: In edge round-robin mode, each 0-to-1 transition on a routed line pulses one core, chosen as in R7. The pointer then moves past that core, so successive transitions visit the set members in rising cyclic order.
- R9: A command accepted at a clock edge changes the outputs from that edge on. A pointer step that falls in the same cycle as a destination write uses the set held before the write.
- R10: Opcode 2 writes the mode of line `cmd_idx`. `cmd_data[1:0]` = 1 selects round-robin and any other value selects fixed-destination. `cmd_data[4]` = 1 selects level and 0 selects edge. All other data bits are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_ready | output | 1 | Always high; command accepted when valid |
| cmd_op | input | 2 | 0 switch, 1 destination, 2 mode, 3 block |
| cmd_idx | input | IDX_W | Common line addressed by the command |
| cmd_data | input | DATA_W | Command payload |
| irq_in | input | N_IRQ | Common interrupt inputs |
| irq_out | output | N_CORES*N_IRQ | Core lines, core c line i at bit c*N_IRQ+i |

## Verification
Two things can land in the same clock edge: a configuration write (destination, mode, block or switch) and an input transition that moves a round-robin pointer or starts an edge pulse. The bench provokes this with a long stretch of random traffic in which commands and input changes are issued together cycle after cycle. It also sweeps every destination set under each of the four mode combinations. A cycle-level model built from the requirements applies the pointer step with the old set and then the write. The outputs are compared against that model in every cycle, so a write that leaks into the current cycle's routing, or that reorders itself against the pointer step, is seen as a mismatch.

// File: rtl/isu_pkg.sv
package isu_pkg;
  typedef enum logic [1:0] {
    OP_SWITCH = 2'd0,
    OP_DEST   = 2'd1,
    OP_MODE   = 2'd2,
    OP_BLOCK  = 2'd3
  } isu_op_e;

  localparam int          MODE_LEVEL_BIT = 4;
  localparam logic [1:0]  SCHEME_ROTATE  = 2'd1;
endpackage

// File: rtl/isu_cfg.sv
module isu_cfg
  import isu_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int N_IRQ   = 4,
  parameter int DATA_W  = 8,
  parameter int IDX_W   = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  input  logic [1:0]                 cmd_op,
  input  logic [IDX_W-1:0]           cmd_idx,
  input  logic [DATA_W-1:0]          cmd_data,
  output logic                       enable_q,
  output logic [N_IRQ-1:0]           mask_q,
  output logic [N_IRQ*N_CORES-1:0]   dest_flat,
  output logic [N_IRQ-1:0]           rr_q,
  output logic [N_IRQ-1:0]           level_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q  <= 1'b0;
      mask_q    <= '1;
      dest_flat <= '0;
      rr_q      <= '0;
      level_q   <= '0;
    end else if (cmd_valid) begin
      case (isu_op_e'(cmd_op))
        OP_SWITCH: enable_q <= cmd_data[0];
        OP_DEST: begin
          for (int i = 0; i < N_IRQ; i++)
            if (cmd_idx == IDX_W'(i))
              dest_flat[i*N_CORES +: N_CORES] <= cmd_data[N_CORES-1:0];
        end
        OP_MODE: begin
          for (int i = 0; i < N_IRQ; i++)
            if (cmd_idx == IDX_W'(i)) begin
              rr_q[i]    <= (cmd_data[1:0] == SCHEME_ROTATE);
              level_q[i] <= cmd_data[MODE_LEVEL_BIT];
            end
        end
        OP_BLOCK: begin
          for (int i = 0; i < N_IRQ; i++)
            if (cmd_idx == IDX_W'(i))
              mask_q[i] <= cmd_data[0];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/isu_pick.sv
module isu_pick #(
  parameter int N  = 4,
  parameter int PW = 2
) (
  input  logic [N-1:0]  cand,
  input  logic [PW-1:0] start,
  output logic [PW-1:0] sel,
  output logic [N-1:0]  hot
);
  // first set candidate at or after start, scanning cyclically upward
  always_comb begin
    logic found;
    found = 1'b0;
    sel   = '0;
    hot   = '0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = int'(start) + k;
      if (j >= N) j = j - N;
      if (!found && cand[j]) begin
        found  = 1'b1;
        sel    = PW'(j);
        hot[j] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/isu_lane.sv
module isu_lane #(
  parameter int N_CORES = 4,
  parameter int PTR_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic               routed,
  input  logic [N_CORES-1:0] dest,
  input  logic               rr,
  input  logic               level,
  output logic [N_CORES-1:0] cores
);
  logic             req_q;
  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] rr_sel, low_sel;
  logic [N_CORES-1:0] rr_hot, low_hot;
  logic live, rise, fall, advance;

  isu_pick #(.N(N_CORES), .PW(PTR_W)) u_pick_rr (
    .cand(dest), .start(ptr_q), .sel(rr_sel), .hot(rr_hot));

  isu_pick #(.N(N_CORES), .PW(PTR_W)) u_pick_low (
    .cand(dest), .start('0), .sel(low_sel), .hot(low_hot));

  assign live    = routed && (|dest);
  assign rise    = req && !req_q;
  assign fall    = req_q && !req;
  assign advance = live && rr && (level ? fall : rise);

  always_comb begin
    cores = '0;
    if (live) begin
      if (level) begin
        if (req) cores = rr ? rr_hot : low_hot;
      end else begin
        if (rise) cores = rr ? rr_hot : dest;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      ptr_q <= '0;
    end else begin
      req_q <= req;
      if (advance)
        ptr_q <= (int'(rr_sel) == N_CORES-1) ? '0 : rr_sel + 1'b1;
    end
  end
endmodule

// File: rtl/irq_spread_unit.sv
module irq_spread_unit #(
  parameter int N_CORES = 4,
  parameter int N_IRQ   = 4,
  parameter int DATA_W  = 8,
  parameter int IDX_W   = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  output logic                     cmd_ready,
  input  logic [1:0]               cmd_op,
  input  logic [IDX_W-1:0]         cmd_idx,
  input  logic [DATA_W-1:0]        cmd_data,
  input  logic [N_IRQ-1:0]         irq_in,
  output logic [N_CORES*N_IRQ-1:0] irq_out
);
  localparam int PTR_W = (N_CORES > 1) ? $clog2(N_CORES) : 1;

  logic                     enable_q;
  logic [N_IRQ-1:0]         mask_q;
  logic [N_IRQ*N_CORES-1:0] dest_flat;
  logic [N_IRQ-1:0]         rr_q;
  logic [N_IRQ-1:0]         level_q;
  logic [N_CORES-1:0]       lane_out [N_IRQ];

  assign cmd_ready = 1'b1;

  isu_cfg #(.N_CORES(N_CORES), .N_IRQ(N_IRQ), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_idx(cmd_idx), .cmd_data(cmd_data), .enable_q(enable_q),
    .mask_q(mask_q), .dest_flat(dest_flat), .rr_q(rr_q), .level_q(level_q));

  for (genvar i = 0; i < N_IRQ; i++) begin : g_lane
    isu_lane #(.N_CORES(N_CORES), .PTR_W(PTR_W)) u_lane (
      .clk(clk), .rst_n(rst_n), .req(irq_in[i]),
      .routed(enable_q && !mask_q[i]),
      .dest(dest_flat[i*N_CORES +: N_CORES]),
      .rr(rr_q[i]), .level(level_q[i]), .cores(lane_out[i]));
    for (genvar c = 0; c < N_CORES; c++) begin : g_core
      assign irq_out[c*N_IRQ + i] = lane_out[i][c];
    end
  end
endmodule

// File: rtl/isu_chk.sv
module isu_chk #(
  parameter int N_CORES = 4,
  parameter int N_IRQ   = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [N_IRQ-1:0]         irq_in,
  input logic [N_CORES*N_IRQ-1:0] irq_out,
  input logic                     enable_q,
  input logic [N_IRQ-1:0]         mask_q,
  input logic [N_IRQ*N_CORES-1:0] dest_flat,
  input logic [N_IRQ-1:0]         rr_q,
  input logic [N_IRQ-1:0]         level_q
);
  logic [N_CORES-1:0] per_line [N_IRQ];

  always_comb
    for (int i = 0; i < N_IRQ; i++)
      for (int c = 0; c < N_CORES; c++)
        per_line[i][c] = irq_out[c*N_IRQ + i];

  // R2
  switch_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_q |-> irq_out == '0);

  for (genvar i = 0; i < N_IRQ; i++) begin : g_line
    // R3
    blocked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mask_q[i] |-> per_line[i] == '0);
    // R4
    empty_set_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dest_flat[i*N_CORES +: N_CORES] == '0) |-> per_line[i] == '0);
    // R7
    single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (level_q[i] || rr_q[i]) |-> $onehot0(per_line[i]));
    // R6
    edge_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!level_q[i] && (|per_line[i])) |=> (level_q[i] || per_line[i] == '0));
    // R5
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (level_q[i] && !rr_q[i] && enable_q && !mask_q[i] &&
       (dest_flat[i*N_CORES +: N_CORES] != '0)) |-> ((|per_line[i]) == irq_in[i]));
  end
endmodule

bind irq_spread_unit isu_chk #(.N_CORES(N_CORES), .N_IRQ(N_IRQ)) u_isu_chk (
  .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .irq_out(irq_out),
  .enable_q(enable_q), .mask_q(mask_q), .dest_flat(dest_flat),
  .rr_q(rr_q), .level_q(level_q));

// File: tb/test_irq_spread_unit.sv
module test_irq_spread_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = '0;
  logic [1:0]  cmd_idx = '0;
  logic [7:0]  cmd_data = '0;
  logic [3:0]  irq_in = '0;
  logic [15:0] irq_out;

  int checks = 0;
  int fails  = 0;
  string phase = "R1";

  // model state
  bit       m_en;
  bit [3:0] m_mask, m_rr, m_lvl, m_inq;
  bit [3:0] m_dest [4];
  int       m_ptr  [4];

  irq_spread_unit i_irq_spread_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_idx(cmd_idx), .cmd_data(cmd_data),
    .irq_in(irq_in), .irq_out(irq_out));

  always #10 clk = ~clk;

  function automatic int pick(input bit [3:0] d, input int start);
    for (int k = 0; k < 4; k++) begin
      int j = (start + k) % 4;
      if (d[j]) return j;
    end
    return -1;
  endfunction

  function automatic bit [15:0] expect_out();
    bit [15:0] e = '0;
    for (int i = 0; i < 4; i++) begin
      bit [3:0] v = '0;
      bit rise = irq_in[i] && !m_inq[i];
      if (m_en && !m_mask[i] && m_dest[i] != 0) begin
        int s = m_rr[i] ? pick(m_dest[i], m_ptr[i]) : pick(m_dest[i], 0);
        if (m_lvl[i]) begin
          if (irq_in[i]) v[s] = 1'b1;
        end else if (rise) begin
          if (m_rr[i]) v[s] = 1'b1; else v = m_dest[i];
        end
      end
      for (int c = 0; c < 4; c++) e[c*4+i] = v[c];
    end
    return e;
  endfunction

  task automatic model_step();
    for (int i = 0; i < 4; i++) begin
      bit rise = irq_in[i] && !m_inq[i];
      bit fall = m_inq[i] && !irq_in[i];
      if (m_en && !m_mask[i] && m_dest[i] != 0 && m_rr[i] &&
          (m_lvl[i] ? fall : rise))
        m_ptr[i] = (pick(m_dest[i], m_ptr[i]) + 1) % 4;
      m_inq[i] = irq_in[i];
    end
    if (cmd_valid) begin
      case (cmd_op)
        2'd0: m_en = cmd_data[0];
        2'd1: m_dest[cmd_idx] = cmd_data[3:0];
        2'd2: begin
          m_rr[cmd_idx]  = (cmd_data[1:0] == 2'd1);
          m_lvl[cmd_idx] = cmd_data[4];
        end
        default: m_mask[cmd_idx] = cmd_data[0];
      endcase
    end
  endtask

  task automatic tick(input bit v, input bit [1:0] op, input bit [1:0] idx,
                      input bit [7:0] d, input bit [3:0] inp);
    bit [15:0] e;
    @(negedge clk);
    cmd_valid = v; cmd_op = op; cmd_idx = idx; cmd_data = d; irq_in = inp;
    #2;
    e = expect_out();
    checks++;
    if (irq_out !== e) begin
      fails++;
      $display("FAIL %s: irq_out=%h expected %h", phase, irq_out, e);
    end
    model_step();
  endtask

  task automatic idle(input bit [3:0] inp);
    tick(1'b0, 2'd0, 2'd0, 8'h00, inp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    m_en = 0; m_mask = 4'hF; m_rr = 0; m_lvl = 0; m_inq = 0;
    for (int i = 0; i < 4; i++) begin m_dest[i] = 0; m_ptr[i] = 0; end
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R1: reset state
    phase = "R1";
    @(negedge clk); #2;
    checks++;
    if (irq_out !== 16'h0 || cmd_ready !== 1'b1) begin
      fails++;
      $display("FAIL R1: irq_out=%h ready=%b expected 0000 ready=1", irq_out, cmd_ready);
    end

    // R2: switch off, everything configured, inputs toggling
    phase = "R2";
    for (int i = 0; i < 4; i++) begin
      tick(1, 2'd1, 2'(i), 8'h0F, 4'h0);
      tick(1, 2'd3, 2'(i), 8'h00, 4'h0);
      tick(1, 2'd2, 2'(i), 8'h10, 4'h0);
    end
    for (int k = 0; k < 8; k++) idle(4'(k[0] ? 4'hF : 4'h0));
    tick(1, 2'd0, 2'd0, 8'h01, 4'h0);

    // R5 R6 R7 R8 R4: sweep each line, mode and destination set
    for (int i = 0; i < 4; i++) begin
      for (int m = 0; m < 4; m++) begin
        bit lvl = m[1];
        bit rot = m[0];
        for (int d = 0; d < 16; d++) begin
          bit [3:0] b = 4'(1 << i);
          if (d == 0) phase = "R4";
          else if (lvl && !rot) phase = "R5";
          else if (!lvl && !rot) phase = "R6";
          else if (lvl) phase = "R7";
          else phase = "R8";
          tick(1, 2'd1, 2'(i), 8'(d), 4'h0);
          tick(1, 2'd2, 2'(i), {3'b0, lvl, 2'b0, 1'b0, rot}, 4'h0);
          idle(b); idle(b); idle(0); idle(b); idle(0);
          idle(b); idle(b); idle(0); idle(b); idle(0);
        end
      end
    end

    // R3: block and unblock with inputs high
    phase = "R3";
    for (int i = 0; i < 4; i++) begin
      tick(1, 2'd1, 2'(i), 8'h06, 4'hF);
      tick(1, 2'd2, 2'(i), 8'h10, 4'hF);
    end
    for (int i = 0; i < 4; i++) begin
      tick(1, 2'd3, 2'(i), 8'h01, 4'hF);
      idle(4'hF);
      tick(1, 2'd3, 2'(i), 8'h00, 4'hF);
      idle(4'hF);
    end

    // R9: destination changes each cycle with input held
    phase = "R9";
    for (int d = 1; d < 16; d++) tick(1, 2'd1, 2'd1, 8'(d), 4'hF);
    tick(1, 2'd2, 2'd2, 8'h11, 4'h4);
    for (int d = 15; d > 0; d--) tick(1, 2'd1, 2'd2, 8'(d), 4'(d[0] ? 4'h4 : 4'h0));

    // R10: reserved bits and non-rotate scheme values
    phase = "R10";
    for (int i = 0; i < 4; i++) tick(1, 2'd1, 2'(i), 8'hFB, 4'h0);
    tick(1, 2'd2, 2'd0, 8'hE5, 4'h0);
    tick(1, 2'd2, 2'd1, 8'h1E, 4'h0);
    tick(1, 2'd2, 2'd2, 8'h13, 4'h0);
    tick(1, 2'd2, 2'd3, 8'hEF, 4'h0);
    for (int k = 0; k < 12; k++) idle(4'(k % 3 == 0 ? 4'h0 : 4'hF));

    // R9: writes coinciding with input edges and pointer steps
    phase = "R9";
    tick(1, 2'd0, 2'd0, 8'h01, 4'h0);
    for (int k = 0; k < 3000; k++) begin
      bit [1:0] op = 2'($urandom_range(0, 3));
      bit [7:0] d  = 8'($urandom);
      if (op == 2'd0) d[0] = ($urandom_range(0, 7) != 0);
      if (op == 2'd3) d[0] = ($urandom_range(0, 3) == 0);
      tick(($urandom_range(0, 2) != 0), op, 2'($urandom), d, 4'($urandom));
    end

    // R2: switch turned off again
    phase = "R2";
    tick(1, 2'd0, 2'd0, 8'h00, 4'h0);
    for (int k = 0; k < 8; k++) idle(4'(k[0] ? 4'hF : 4'h0));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule